// File: doc/BRIEF.md
# Surge-Limited Power-Switch Wake-Up Sequencer

This block brings a row of power-gating footer switches back on after a sleep period without letting the combined inrush current exceed a programmable limit. The row is indexed 0 to N_SW-1 by physical position. Each switch has a static rank, supplied by the power controller, and a discharge-current estimate that is refreshed from outside on every interval tick. When the estimates fall as the virtual ground drains, more switches fit under the limit.

A wake request arms the block. On each tick it latches the estimates and adds up the current of the switches that are already on. It then walks the switches that are still off, highest rank first. A switch is turned on only if it touches one end of the run that is already on and its estimate still fits in the remaining budget. The enabled switches therefore always form one run that grows outward from the first switch. The block records the interval in which each switch came on. It pulses a done flag once the whole row is on, and holds that state until a sleep command clears it.

Top module: `surge_wake_seq`

## Requirements
- R1: After reset, and after a sleep command, every enable, every recorded interval, the done flag and the over-budget flag read zero.
- R2: No switch is enabled before the first tick that follows a wake request. On that tick, the switch with the largest rank value is enabled first, with ties going to the lowest index, and its recorded interval is 0.
- R3: The enabled switches always form a single contiguous run. After the first switch, a switch is enabled only if its index is one below the lowest enabled index or one above the highest.
- R4: A switch is enabled only if its latched estimate plus the sum of the latched estimates of all already-enabled switches is less than or equal to the budget. That sum is rebuilt from the estimates latched at each tick.
- R5: Within one interval, candidates are taken in decreasing rank order, and several switches may be enabled in the same interval. After each enable, the walk restarts from the highest-ranked switch still off, so a switch skipped earlier for not being adjacent can be taken once it becomes adjacent. At most one switch is enabled per clock.
- R6: The first switch is enabled even if its estimate alone exceeds the budget. In that case the over-budget flag goes high and stays high until a sleep command.
- R7: When no candidate fits, the block waits for the next tick and re-evaluates with the refreshed estimates. The interval index starts at 0 and advances by one for each tick whose walk ends without completing the row. Each switch records the index of the interval in which it was enabled, in field [IDX_W*i +: IDX_W] of the record output.
- R8: An enabled switch is never disabled except by a sleep command.
- R9: The done flag is high for exactly one clock, in the cycle after the one in which the last enable first appears.
- R10: A wake request has no effect unless the block is idle. A sleep command takes priority over everything else and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_req | input | 1 | Start a wake-up sequence (idle only) |
| sleep_cmd | input | 1 | Return to idle; clears all switches and records |
| tick | input | 1 | Interval boundary; estimates are valid |
| cur_est | input | N_SW*CUR_W | Per-switch current estimate, switch i at [CUR_W*i +: CUR_W] |
| prio | input | N_SW*PRI_W | Per-switch static rank, larger is earlier |
| budget | input | SUM_W | Surge-current limit |
| sw_en | output | N_SW | Per-switch enable |
| done | output | 1 | One-clock pulse after the whole row is on |
| over_budget | output | 1 | Sticky: the first switch alone exceeded the budget |
| on_ivl | output | N_SW*IDX_W | Interval index at which each switch was enabled |

## Verification
On every cycle, the assertions check that the enables never drop outside a sleep command, that the enabled set stays one contiguous run, that no more than one switch is added per clock, that the done pulse lasts one cycle and only with the row full, and that a sleep command clears the outputs. The choice of which switch comes on, the inclusive budget comparison, the re-evaluation with fresh estimates on a later tick, the recorded interval indices and the forced first enable can only be shown by the bench. It does this with scenarios whose per-tick outcomes are worked out by hand from the ranks, estimates and budget.

// File: rtl/surge_wake_seq.sv
module surge_wake_seq #(
  parameter int N_SW  = 5,
  parameter int CUR_W = 8,
  parameter int PRI_W = 8,
  parameter int IDX_W = 4,
  localparam int SUM_W = CUR_W + $clog2(N_SW + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wake_req,
  input  logic                   sleep_cmd,
  input  logic                   tick,
  input  logic [N_SW*CUR_W-1:0]  cur_est,
  input  logic [N_SW*PRI_W-1:0]  prio,
  input  logic [SUM_W-1:0]       budget,
  output logic [N_SW-1:0]        sw_en,
  output logic                   done,
  output logic                   over_budget,
  output logic [N_SW*IDX_W-1:0]  on_ivl
);
  localparam int POS_W = (N_SW > 1) ? $clog2(N_SW) : 1;
  localparam int PW1   = POS_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_SUM, S_SCAN, S_FULL} st_t;

  st_t                  st;
  logic [N_SW*CUR_W-1:0] est_q;
  logic [SUM_W-1:0]     sum_q, en_sum, sum_next;
  logic [POS_W-1:0]     lo, hi, cand;
  logic [N_SW-1:0]      seen;
  logic [IDX_W-1:0]     ivl;
  logic                 full_d;
  logic                 found, first, adj, fits, take, all_after;
  logic [PRI_W-1:0]     best;
  logic [CUR_W-1:0]     cand_est;

  always_comb begin
    found = 1'b0;
    cand  = '0;
    best  = '0;
    for (int i = 0; i < N_SW; i++) begin
      if (!sw_en[i] && !seen[i] && (!found || prio[i*PRI_W +: PRI_W] > best)) begin
        found = 1'b1;
        cand  = POS_W'(i);
        best  = prio[i*PRI_W +: PRI_W];
      end
    end
  end

  always_comb begin
    en_sum = '0;
    for (int i = 0; i < N_SW; i++)
      if (sw_en[i]) en_sum = en_sum + SUM_W'(est_q[i*CUR_W +: CUR_W]);
  end

  assign cand_est  = est_q[cand*CUR_W +: CUR_W];
  assign sum_next  = sum_q + SUM_W'(cand_est);
  assign fits      = sum_next <= budget;
  assign first     = (sw_en == '0);
  assign adj       = (PW1'(cand) + PW1'(1) == PW1'(lo)) || (PW1'(cand) == PW1'(hi) + PW1'(1));
  assign take      = found && (first || (adj && fits));
  assign all_after = &(sw_en | (N_SW'(1) << cand));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sw_en <= '0; on_ivl <= '0; over_budget <= 1'b0;
      est_q <= '0; sum_q <= '0; lo <= '0; hi <= '0; seen <= '0; ivl <= '0;
      full_d <= 1'b0; done <= 1'b0;
    end else if (sleep_cmd) begin
      st <= S_IDLE; sw_en <= '0; on_ivl <= '0; over_budget <= 1'b0;
      sum_q <= '0; seen <= '0; ivl <= '0;
      full_d <= 1'b0; done <= 1'b0;
    end else begin
      full_d <= &sw_en;
      done   <= (&sw_en) & ~full_d;
      case (st)
        S_IDLE: if (wake_req) begin
          st  <= S_ARM;
          ivl <= '0;
        end
        S_ARM: if (tick) begin
          est_q <= cur_est;
          st    <= S_SUM;
        end
        S_SUM: begin
          sum_q <= en_sum;
          seen  <= '0;
          st    <= S_SCAN;
        end
        S_SCAN: begin
          if (!found) begin
            if (ivl != '1) ivl <= ivl + IDX_W'(1);
            st <= S_ARM;
          end else if (take) begin
            sw_en[cand] <= 1'b1;
            on_ivl[cand*IDX_W +: IDX_W] <= ivl;
            sum_q <= sum_next;
            seen  <= '0;
            if (first) begin
              lo <= cand;
              hi <= cand;
              if (!fits) over_budget <= 1'b1;
            end else if (cand < lo) begin
              lo <= cand;
            end else begin
              hi <= cand;
            end
            if (all_after) st <= S_FULL;
          end else begin
            seen[cand] <= 1'b1;
          end
        end
        default: st <= S_FULL;
      endcase
    end
  end
endmodule

// File: rtl/surge_wake_chk.sv
module surge_wake_chk #(
  parameter int N_SW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sleep_cmd,
  input logic [N_SW-1:0] sw_en,
  input logic            done,
  input logic            over_budget
);
  int runs;
  always_comb begin
    runs = sw_en[0] ? 1 : 0;
    for (int i = 1; i < N_SW; i++)
      if (sw_en[i] && !sw_en[i-1]) runs = runs + 1;
  end

  assert_enables_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_cmd |=> ((sw_en & $past(sw_en)) == $past(sw_en)));

  assert_single_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    runs <= 1);

  assert_one_add_per_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_cmd |=> $countones(sw_en & ~$past(sw_en)) <= 1);

  assert_done_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> &sw_en);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_sleep_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_cmd |=> (sw_en == '0) && !over_budget && !done);

  assert_over_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (over_budget && !sleep_cmd) |=> over_budget);
endmodule

bind surge_wake_seq surge_wake_chk #(.N_SW(N_SW)) chk_i (
  .clk(clk), .rst_n(rst_n), .sleep_cmd(sleep_cmd),
  .sw_en(sw_en), .done(done), .over_budget(over_budget)
);

// File: tb/surge_wake_seq_tb.sv
module surge_wake_seq_tb_top;
  localparam int N = 5, CW = 8, PW = 8, IW = 4, SW = CW + 3;

  logic clk = 0, rst_n = 0, wake_req = 0, sleep_cmd = 0, tick = 0;
  logic [N*CW-1:0] cur_est = '0;
  logic [N*PW-1:0] prio = '0;
  logic [SW-1:0] budget = '0;
  logic [N-1:0] sw_en;
  logic done, over_budget;
  logic [N*IW-1:0] on_ivl;

  int total = 0, bad = 0, done_seen = 0, done_age = -1, full_age = 0;

  always #10 clk = ~clk;

  surge_wake_seq #(.N_SW(N), .CUR_W(CW), .PRI_W(PW), .IDX_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .sleep_cmd(sleep_cmd), .tick(tick),
    .cur_est(cur_est), .prio(prio), .budget(budget), .sw_en(sw_en), .done(done),
    .over_budget(over_budget), .on_ivl(on_ivl));

  always @(negedge clk) begin
    if (done) begin done_seen <= done_seen + 1; done_age <= full_age; end
    full_age <= (&sw_en) ? full_age + 1 : 0;
  end

  // {est4,est3,est2,est1,est0, expected enables}
  localparam logic [N*CW+N-1:0] VEC [4] = '{
    {8'd60, 8'd60, 8'd60, 8'd60, 8'd60, 5'b00100},
    {8'd30, 8'd30, 8'd40, 8'd30, 8'd30, 5'b11100},
    {8'd25, 8'd25, 8'd25, 8'd25, 8'd25, 5'b11110},
    {8'd10, 8'd10, 8'd10, 8'd10, 8'd10, 5'b11111}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_tick(input logic [N*CW-1:0] e);
    @(negedge clk); cur_est = e; tick = 1;
    @(negedge clk); tick = 0;
    repeat (60) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) wake_req = 1; else sleep_cmd = 1;
    @(negedge clk); wake_req = 0; sleep_cmd = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 enables after reset", 64'(sw_en), 0);
    chk("R1 done after reset", 64'(done), 0);
    chk("R1 over after reset", 64'(over_budget), 0);
    chk("R1 records after reset", 64'(on_ivl), 0);

    // Scenario A: ranks idx4..0 = 40,30,50,20,10; budget 100
    prio = {8'd40, 8'd30, 8'd50, 8'd20, 8'd10};
    budget = 11'd100;
    pulse(0);
    repeat (10) @(negedge clk);
    chk("R2 nothing before first tick", 64'(sw_en), 0);
    for (int v = 0; v < 4; v++) begin
      pulse_tick(VEC[v][N*CW+N-1:N]);
      chk($sformatf("R3 R4 R5 R7 table step %0d enables", v), 64'(sw_en), 64'(VEC[v][N-1:0]));
    end
    chk("R2 R7 recorded intervals A", 64'(on_ivl), 64'({4'd1, 4'd1, 4'd0, 4'd2, 4'd3}));
    chk("R6 no over flag when first fits", 64'(over_budget), 0);
    chk("R9 one done pulse A", 64'(done_seen), 1);
    chk("R9 done one cycle after full", 64'(done_age), 1);
    pulse(0);
    chk("R10 wake ignored while full", 64'(sw_en), 64'h1f);
    chk("R10 wake gives no extra done", 64'(done_seen), 1);
    pulse(1);
    chk("R10 R1 sleep clears enables", 64'(sw_en), 0);
    chk("R1 sleep clears records", 64'(on_ivl), 0);

    // Scenario B: equal ranks, budget 20, forced first enable
    prio = {N{8'd7}};
    budget = 11'd20;
    pulse(0);
    pulse_tick({N{8'd50}});
    chk("R2 tie goes to lowest index", 64'(sw_en), 64'b00001);
    chk("R6 over flag on forced first", 64'(over_budget), 1);
    pulse_tick({N{8'd5}});
    chk("R4 inclusive budget fill", 64'(sw_en), 64'b01111);
    pulse(0);
    chk("R10 wake ignored mid-sequence", 64'(sw_en), 64'b01111);
    chk("R8 records kept mid-sequence", 64'(on_ivl), 64'({4'd0, 4'd1, 4'd1, 4'd1, 4'd0}));
    pulse_tick({N{8'd0}});
    chk("R8 R7 row complete B", 64'(sw_en), 64'h1f);
    chk("R7 recorded intervals B", 64'(on_ivl), 64'({4'd2, 4'd1, 4'd1, 4'd1, 4'd0}));
    chk("R6 over flag sticky", 64'(over_budget), 1);
    chk("R9 second done pulse", 64'(done_seen), 2);
    pulse(1);
    chk("R6 R10 sleep clears over flag", 64'(over_budget), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule